// File: doc/BRIEF.md
# Per-Core Exclusive Reservation Monitor

This block follows exclusive-access reservations for a single processor core. It sits next to the core's load/store path and looks at one memory request per cycle. The request can be an ordinary load or store, a load-exclusive (plain or acquire form), a store-exclusive (plain or release form), or a clear-exclusive. From a two-state machine (open or armed), it decides in the same cycle whether a store-exclusive may write to memory, and it returns a one-bit status for the register file.

A load-exclusive arms the monitor. It also latches the base address of the aligned granule that holds the request address, and that base is exported to the system-level monitor. The granule size is set by a parameter. A store-exclusive succeeds only if the monitor is armed, whatever address armed it. A success, or a clear, returns the monitor to open. Ordinary traffic passes through and does not touch the reservation. Cache coherence, the memory array and cross-core checking are handled elsewhere.

Top module: `excl_mon_top`

## Requirements
- R1: After reset the monitor is open: `resv_valid` is 0 and `resv_addr` is 0.
- R2: A load-exclusive (`req_op` 2 or 3) arms the monitor from the next cycle. In its own cycle it asserts `mem_rd_en`, and `core_rdata` equals `mem_rdata`.
- R3: A load-exclusive that arrives while the monitor is armed keeps it armed, with no error. The recorded address is replaced by the new granule base.
- R4: A store-exclusive (`req_op` 4 or 5) on an armed monitor asserts `mem_wr_en` and returns `st_status` 0 in the same cycle. The monitor is open from the next cycle.
- R5: A store-exclusive on an open monitor holds `mem_wr_en` at 0 and returns `st_status` 1. The monitor stays open.
- R6: A clear-exclusive (`req_op` 6) opens the monitor from the next cycle. It asserts neither `mem_rd_en` nor `mem_wr_en`.
- R7: `resv_addr` is the last load-exclusive address with its low `GRAN_LOG2` bits cleared (granule of 2^GRAN_LOG2 bytes, default 16).
- R8: The outcome of a store-exclusive does not depend on its address. Any armed reservation lets it pass.
- R9: An ordinary load (`req_op` 0) or store (`req_op` 1) asserts `mem_rd_en` or `mem_wr_en` respectively. It leaves `resv_valid` and `resv_addr` unchanged.
- R10: `st_status_valid` is 1 only in a cycle carrying a store-exclusive. In every other cycle `st_status` is 0.
- R11: A cycle with `req_valid` 0, or with `req_op` 7, drives no memory enable and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | 0 load, 1 store, 2/3 load-excl, 4/5 store-excl, 6 clear, 7 none |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Store data |
| mem_rdata | input | DATA_W | Data returned by memory |
| mem_rd_en | output | 1 | Memory read enable |
| mem_wr_en | output | 1 | Memory write enable after gating |
| mem_addr | output | ADDR_W | Address forwarded to memory |
| mem_wdata | output | DATA_W | Write data forwarded to memory |
| core_rdata | output | DATA_W | Load data returned to the core |
| st_status_valid | output | 1 | A store-exclusive status is present |
| st_status | output | 1 | 0 pass, 1 fail |
| resv_valid | output | 1 | Monitor is armed |
| resv_addr | output | ADDR_W | Reserved granule base, exported |

## Verification
The bench sends a weighted random mix of all eight operation codes over addresses from a small pool. This makes the same granule, other granules and unaligned offsets all occur. The mix separates armed-state behaviour from address-dependent behaviour, since a store-exclusive to an unrelated address must still pass. Directed sequences exercise the corner cases: a double load-exclusive, a store after a failed store, a clear followed by a store, and ordinary traffic placed between an arm and its store. These separate a state machine that is correct from one that ignores re-arming, keeps the reservation after a failure, or lets plain stores disarm it.

// File: rtl/excl_mon_pkg.sv
// Package: shared operation codes and monitor state for the exclusive monitor.
// Assumes the 3-bit operation field encoding listed in the brief.
package excl_mon_pkg;

    typedef enum logic [2:0] {
        OP_LD   = 3'd0,
        OP_ST   = 3'd1,
        OP_LDX  = 3'd2,
        OP_LDAX = 3'd3,
        OP_STX  = 3'd4,
        OP_STLX = 3'd5,
        OP_CLRX = 3'd6,
        OP_NONE = 3'd7
    } mon_op_e;

    typedef enum logic {
        MON_OPEN  = 1'b0,
        MON_ARMED = 1'b1
    } mon_state_e;

    typedef struct packed {
        logic plain_ld;
        logic plain_st;
        logic excl_ld;
        logic excl_st;
        logic clr;
    } op_class_t;

endpackage

// File: rtl/excl_mon_decode.sv
// Module: classifies a request into one-hot operation classes.
// Assumes req_op follows mon_op_e; an invalid cycle yields all zeros.
module excl_mon_decode
    import excl_mon_pkg::*;
(
    input  logic       valid,
    input  logic [2:0] op,
    output op_class_t  cls
);

    mon_op_e op_e;

    // Decode the operation field into class flags.
    always_comb begin
        op_e = mon_op_e'(op);
        cls  = '0;
        if (valid) begin
            unique case (op_e)
                OP_LD:           cls.plain_ld = 1'b1;
                OP_ST:           cls.plain_st = 1'b1;
                OP_LDX, OP_LDAX: cls.excl_ld  = 1'b1;
                OP_STX, OP_STLX: cls.excl_st  = 1'b1;
                OP_CLRX:         cls.clr      = 1'b1;
                default:         cls          = '0;
            endcase
        end
    end

endmodule

// File: rtl/excl_mon_fsm.sv
// Module: two-state open/armed reservation state machine.
// Assumes at most one classified request per cycle; synchronous active-low reset.
module excl_mon_fsm
    import excl_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  op_class_t  cls,
    output mon_state_e state
);

    mon_state_e state_nxt;

    // Next-state selection from the current request class.
    always_comb begin
        state_nxt = state;
        if (cls.excl_ld)
            state_nxt = MON_ARMED;
        else if (cls.excl_st || cls.clr)
            state_nxt = MON_OPEN;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= MON_OPEN;
        else        state <= state_nxt;
    end

endmodule

// File: rtl/excl_mon_resv.sv
// Module: holds the granule base of the latest load-exclusive.
// Assumes GRAN_LOG2 < ADDR_W; the value is kept after disarm for the system side.
module excl_mon_resv #(
    parameter int ADDR_W    = 32,
    parameter int GRAN_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] base
);

    localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << GRAN_LOG2) - ADDR_W'(1);

    // Latch the aligned base address on each capture.
    always_ff @(posedge clk) begin
        if (!rst_n)       base <= '0;
        else if (capture) base <= addr & ~LOW_MASK;
    end

endmodule

// File: rtl/excl_mon_gate.sv
// Module: same-cycle memory enables and store-exclusive status.
// Assumes the armed flag reflects the state before this cycle's request.
module excl_mon_gate
    import excl_mon_pkg::*;
(
    input  op_class_t cls,
    input  logic      armed,
    output logic      rd_en,
    output logic      wr_en,
    output logic      stat_valid,
    output logic      stat_fail
);

    // Derive enables and pass/fail from class and current arming.
    always_comb begin
        rd_en      = cls.plain_ld | cls.excl_ld;
        wr_en      = cls.plain_st | (cls.excl_st & armed);
        stat_valid = cls.excl_st;
        stat_fail  = cls.excl_st & ~armed;
    end

endmodule

// File: rtl/excl_mon_top.sv
// Module: per-core exclusive monitor top; wires decode, state, reservation, gating.
// Assumes one request per cycle and a memory that honours mem_wr_en in the same cycle.
module excl_mon_top
    import excl_mon_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 64,
    parameter int GRAN_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] core_rdata,
    output logic              st_status_valid,
    output logic              st_status,
    output logic              resv_valid,
    output logic [ADDR_W-1:0] resv_addr
);

    op_class_t  cls;
    mon_state_e state;

    excl_mon_decode u_dec (
        .valid (req_valid),
        .op    (req_op),
        .cls   (cls)
    );

    excl_mon_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .cls   (cls),
        .state (state)
    );

    excl_mon_resv #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_resv (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cls.excl_ld),
        .addr    (req_addr),
        .base    (resv_addr)
    );

    excl_mon_gate u_gate (
        .cls        (cls),
        .armed      (state == MON_ARMED),
        .rd_en      (mem_rd_en),
        .wr_en      (mem_wr_en),
        .stat_valid (st_status_valid),
        .stat_fail  (st_status)
    );

    // Forward address/data and return load data only on loads.
    always_comb begin
        mem_addr   = req_addr;
        mem_wdata  = req_wdata;
        resv_valid = (state == MON_ARMED);
        core_rdata = mem_rd_en ? mem_rdata : '0;
    end

endmodule

// File: rtl/excl_mon_chk.sv
// Module: assertion checker for excl_mon_top, attached by bind below.
// Assumes the operation encoding of the brief.
module excl_mon_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [2:0] req_op,
    input logic       mem_rd_en,
    input logic       mem_wr_en,
    input logic       st_status_valid,
    input logic       st_status,
    input logic       resv_valid
);

    logic is_stx, is_ldx, is_clr, is_plain, is_idle;

    // Classify the request independently of the design's decoder.
    always_comb begin
        is_stx   = req_valid && (req_op == 3'd4 || req_op == 3'd5);
        is_ldx   = req_valid && (req_op == 3'd2 || req_op == 3'd3);
        is_clr   = req_valid && (req_op == 3'd6);
        is_plain = req_valid && (req_op == 3'd0 || req_op == 3'd1);
        is_idle  = !req_valid || (req_op == 3'd7);
    end

    assert_arm_on_ldx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_ldx |=> resv_valid);

    assert_pass_when_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_stx && resv_valid) |-> (mem_wr_en && !st_status));

    assert_open_after_stx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_stx |=> !resv_valid);

    assert_fail_when_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_stx && !resv_valid) |-> (!mem_wr_en && st_status));

    assert_clear_no_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_clr |-> (!mem_wr_en && !mem_rd_en));

    assert_clear_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_clr |=> !resv_valid);

    assert_plain_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_plain || is_idle) |=> $stable(resv_valid));

    assert_status_only_on_stx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !is_stx |-> (!st_status_valid && !st_status));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        is_idle |-> (!mem_rd_en && !mem_wr_en));

endmodule

bind excl_mon_top excl_mon_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_op          (req_op),
    .mem_rd_en       (mem_rd_en),
    .mem_wr_en       (mem_wr_en),
    .st_status_valid (st_status_valid),
    .st_status       (st_status),
    .resv_valid      (resv_valid)
);

// File: tb/sim_excl_mon_top.sv
// Bench: random plus directed stimulus against a behavioural reference model.
module sim_excl_mon_top;

    localparam int AW = 32;
    localparam int DW = 64;
    localparam int GL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = 3'd7;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_rd_en, mem_wr_en, st_status_valid, st_status, resv_valid;
    logic [AW-1:0] mem_addr, resv_addr;
    logic [DW-1:0] mem_wdata, core_rdata;

    int errors = 0;
    int checks = 0;
    bit m_armed = 1'b0;
    logic [AW-1:0] m_addr = '0;

    always #2 clk = ~clk;

    excl_mon_top #(.ADDR_W(AW), .DATA_W(DW), .GRAN_LOG2(GL)) u0 (.*);

    function automatic bit f_rd(bit v, logic [2:0] op);
        return v && (op == 3'd0 || op == 3'd2 || op == 3'd3);
    endfunction

    function automatic bit f_wr(bit v, logic [2:0] op, bit armed);
        return v && (op == 3'd1 || ((op == 3'd4 || op == 3'd5) && armed));
    endfunction

    function automatic bit f_stv(bit v, logic [2:0] op);
        return v && (op == 3'd4 || op == 3'd5);
    endfunction

    task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One request: check same-cycle outputs, then the registered state after the edge.
    task automatic step(bit v, logic [2:0] op, logic [AW-1:0] a);
        logic [DW-1:0] rd;
        @(negedge clk);
        rd = {$urandom, $urandom};
        req_valid = v; req_op = op; req_addr = a;
        req_wdata = {$urandom, $urandom}; mem_rdata = rd;
        #1;
        chk("R2/R9/R11 rd_en", AW'(mem_rd_en), AW'(f_rd(v, op)));
        chk("R4/R5/R8 wr_en", AW'(mem_wr_en), AW'(f_wr(v, op, m_armed)));
        chk("R10 status_valid", AW'(st_status_valid), AW'(f_stv(v, op)));
        chk("R4/R5/R10 status", AW'(st_status), AW'(f_stv(v, op) && !m_armed));
        if (f_rd(v, op)) chk("R2 core_rdata", core_rdata[AW-1:0], rd[AW-1:0]);
        @(posedge clk);
        if (v && (op == 3'd2 || op == 3'd3)) begin
            m_armed = 1'b1;
            m_addr  = a & ~AW'(32'hF);
        end else if (v && (op >= 3'd4 && op <= 3'd6)) begin
            m_armed = 1'b0;
        end
        #1;
        chk("R3/R4/R6/R9 resv_valid", AW'(resv_valid), AW'(m_armed));
        chk("R3/R7/R9 resv_addr", resv_addr, m_addr);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 resv_valid", AW'(resv_valid), '0);
        chk("R1 resv_addr", resv_addr, '0);
        @(negedge clk) rst_n = 1'b1;

        // Directed corner cases.
        step(1, 3'd4, 32'h100);              // R5 store on open fails
        step(1, 3'd2, 32'h1237);             // R2 arm, R7 base 0x1230
        step(1, 3'd3, 32'h4449);             // R3 re-arm, base moves
        step(1, 3'd0, 32'h10);               // R9 plain load keeps state
        step(1, 3'd1, 32'h20);               // R9 plain store keeps state
        step(0, 3'd4, 32'h30);               // R11 invalid cycle quiet
        step(1, 3'd7, 32'h30);               // R11 no-op code
        step(1, 3'd5, 32'hABCD0);            // R8 other address still passes
        step(1, 3'd4, 32'h4440);             // R5 second store fails
        step(1, 3'd2, 32'h8000);
        step(1, 3'd6, 32'h0);                // R6 clear
        step(1, 3'd4, 32'h8000);             // R5 fails after clear

        // Weighted random traffic.
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [2:0] op;
            r  = $urandom_range(0, 99);
            op = (r < 30) ? 3'(2 + $urandom_range(0, 1)) :
                 (r < 60) ? 3'(4 + $urandom_range(0, 1)) :
                 (r < 70) ? 3'd6 : 3'($urandom_range(0, 7));
            step($urandom_range(0, 9) != 0, op,
                 AW'($urandom_range(0, 7)) * AW'(32'h1000) + AW'($urandom_range(0, 31)));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule